// File: doc/BRIEF.md
# Multi-Format Serial Receive Engine

This block turns a serial input line into bytes. It handles four frame formats, chosen by a two-bit mode input. Modes 0 and 3 are asynchronous frames with an optional parity slot. Mode 1 is an asynchronous multiprocessor frame that carries an extra address/data marker bit. Mode 2 is synchronous reception clocked by an external shift clock, with or without start/stop framing. In the asynchronous modes the line is oversampled by the system clock, with one bit lasting `OVS` clock cycles. Each bit is sampled at its midpoint. In mode 2 the line is sampled on rising edges of the shift clock. Both the shift clock and the data line pass through two-stage synchronizers.

Each completed frame sets a receive-full flag and may also set parity, framing and overrun error flags. All of these drive one interrupt request, which is gated by an enable input. Software-side logic clears the full flag with a one-cycle read-acknowledge strobe and clears the error flags with a separate error-clear strobe. When a flag is set the stored byte is only meaningful if no error flag is set. The one exception is overrun: the byte from the earlier frame is kept.

Top module: `serial_rx_multi`

## Requirements
- R1: In mode 0 without parity, a frame is one low start bit, 8 data bits sent LSB first, and a stop bit. Each bit lasts `OVS` clocks and is sampled at its midpoint. The full flag is set when the stop bit is sampled.
- R2: A low pulse on the idle line that has already returned high at the start bit's midpoint is ignored. No flag is set, and a later valid frame is received normally.
- R3: In mode 0 with `parity_en`=1, the eighth bit position carries parity and `rx_data[7]` reads 0. `parity_odd`=0 selects even parity, where data and parity together hold an even number of ones. `parity_odd`=1 selects odd parity. A mismatch sets `par_err`.
- R4: In mode 3 with `parity_en`=1, the eighth position is removed from the data (`rx_data[7]`=0) but is never checked. In modes 1 and 3, `par_err` is never set.
- R5: In mode 1 a frame carries 8 data bits, then a ninth marker bit, then the stop bit. The marker bit appears on `rx_adr_bit` together with the byte.
- R6: In all framed formats, a stop bit sampled as 0 sets `frm_err`. The full flag is still set.
- R7: A frame that completes while `rx_full` is still 1 sets `ovr_err` and keeps the earlier byte. If `rd_ack` is high in the very cycle a frame completes, the earlier frame counts as read: no overrun, the new byte is stored, and `rx_full` stays 1.
- R8: Reset clears all flags. `rd_ack` clears `rx_full`. `err_clr` clears `par_err`, `ovr_err` and `frm_err`.
- R9: `irq` is 1 exactly when `irq_en` is 1 and at least one of `rx_full`, `par_err`, `ovr_err` or `frm_err` is 1.
- R10: In mode 2 with `sync_frame_en`=0, data bits are taken LSB first on each rising `sclk_in` edge. The full flag is set right after the eighth bit, before any further shift clock edge.
- R11: In mode 2 with `sync_frame_en`=1, a frame starts on a shift-clock edge that samples a 0. Eight data bits follow, then a stop bit. A stop bit of 0 sets `frm_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, also the oversampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_in | input | 1 | Serial data line, idle high |
| sclk_in | input | 1 | External shift clock for mode 2 |
| mode | input | 2 | Frame format: 0 async, 1 multiprocessor, 2 synchronous, 3 async |
| sync_frame_en | input | 1 | Mode 2: expect start and stop bits |
| parity_en | input | 1 | Eighth bit position carries parity (modes 0 and 3) |
| parity_odd | input | 1 | 1 selects odd parity, 0 selects even parity |
| irq_en | input | 1 | Receive interrupt enable |
| rd_ack | input | 1 | One-cycle strobe that clears the full flag |
| err_clr | input | 1 | One-cycle strobe that clears the error flags |
| rx_data | output | DW | Received byte |
| rx_adr_bit | output | 1 | Mode 1 address/data marker |
| rx_full | output | 1 | Receive-full flag |
| par_err | output | 1 | Parity error flag |
| ovr_err | output | 1 | Overrun error flag |
| frm_err | output | 1 | Framing error flag |
| irq | output | 1 | Receive interrupt request |

## Verification
A frame can complete in the same cycle that the read-acknowledge strobe clears the previous one. If this is handled wrongly, a byte that was in fact read is reported as an overrun. The bench provokes this in unframed synchronous mode, where the completion cycle is fixed by the shift clock edge. It leaves a first byte unread, then raises `rd_ack` for exactly the cycle in which the eighth bit of the second byte lands. It then requires `ovr_err` to stay 0, `rx_full` to stay 1 and the new byte to be stored.

// File: rtl/serial_rx_multi.sv
module serial_rx_multi #(
  parameter int OVS = 16,
  parameter int DW  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_in,
  input  logic          sclk_in,
  input  logic [1:0]    mode,
  input  logic          sync_frame_en,
  input  logic          parity_en,
  input  logic          parity_odd,
  input  logic          irq_en,
  input  logic          rd_ack,
  input  logic          err_clr,
  output logic [DW-1:0] rx_data,
  output logic          rx_adr_bit,
  output logic          rx_full,
  output logic          par_err,
  output logic          ovr_err,
  output logic          frm_err,
  output logic          irq
);
  localparam int CW = $clog2(OVS);
  localparam int BW = $clog2(DW + 1);

  typedef enum logic [1:0] {IDLE, START, SHIFT, STOP} st_t;
  st_t st;

  logic [2:0]    rx_sy, ck_sy;
  logic [CW-1:0] cnt;
  logic [BW-1:0] nbit;
  logic [DW:0]   sh, sh_nx;

  wire          rx_s     = rx_sy[1];
  wire          rx_fall  = rx_sy[2] & ~rx_sy[1];
  wire          sync_md  = (mode == 2'd2);
  wire          framed   = ~sync_md | sync_frame_en;
  wire          mid      = (cnt == CW'(OVS / 2 - 1));
  wire          tick     = sync_md ? (ck_sy[1] & ~ck_sy[2]) : (cnt == CW'(OVS - 1));
  wire [BW-1:0] last_idx = (mode == 2'd1) ? BW'(DW) : BW'(DW - 1);
  wire          shift_en = (st == SHIFT) & tick;
  wire          done     = ((st == STOP) & tick) | (shift_en & ~framed & (nbit == last_idx));
  wire          par_slot = parity_en & ((mode == 2'd0) | (mode == 2'd3));
  wire          perr_new = parity_en & (mode == 2'd0) & ((^sh[DW-1:0]) != parity_odd);
  wire          ferr_new = (st == STOP) & ~rx_s;

  always_comb begin
    sh_nx = sh;
    if (shift_en) sh_nx[nbit] = rx_s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= IDLE;
      cnt   <= '0;
      nbit  <= '0;
      sh    <= '0;
      rx_sy <= '1;
      ck_sy <= '0;
    end else begin
      rx_sy <= {rx_sy[1:0], rx_in};
      ck_sy <= {ck_sy[1:0], sclk_in};
      sh    <= sh_nx;
      if (st == IDLE || tick || (st == START && mid)) cnt <= '0;
      else cnt <= cnt + 1'b1;
      unique case (st)
        IDLE: begin
          nbit <= '0;
          if (!sync_md && rx_fall) st <= START;
          else if (sync_md && !sync_frame_en) st <= SHIFT;
          else if (sync_md && tick && !rx_s) st <= SHIFT;
        end
        START: if (mid) st <= rx_s ? IDLE : SHIFT;
        SHIFT: if (tick) begin
          if (nbit == last_idx) begin
            nbit <= '0;
            if (framed) st <= STOP;
          end else begin
            nbit <= nbit + 1'b1;
          end
        end
        STOP: if (tick) st <= IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_full    <= 1'b0;
      par_err    <= 1'b0;
      ovr_err    <= 1'b0;
      frm_err    <= 1'b0;
      rx_adr_bit <= 1'b0;
      rx_data    <= '0;
    end else begin
      if (rd_ack) rx_full <= 1'b0;
      if (err_clr) begin
        par_err <= 1'b0;
        ovr_err <= 1'b0;
        frm_err <= 1'b0;
      end
      if (done) begin
        if (rx_full && !rd_ack) begin
          ovr_err <= 1'b1;
        end else begin
          rx_full    <= 1'b1;
          rx_data    <= par_slot ? {1'b0, sh_nx[DW-2:0]} : sh_nx[DW-1:0];
          rx_adr_bit <= (mode == 2'd1) & sh_nx[DW];
        end
        if (perr_new) par_err <= 1'b1;
        if (ferr_new) frm_err <= 1'b1;
      end
    end
  end

  assign irq = irq_en & (rx_full | par_err | ovr_err | frm_err);

  a_r2_glitch_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (st == START && mid && rx_s) |=> (st == IDLE));

  a_r4_no_parity_flag: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(par_err) |-> ($past(mode) == 2'd0));

  a_r7_overrun_keeps_byte: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr_err) |-> $stable(rx_data));

  a_r8_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ack && !done) |=> !rx_full);

  a_r9_irq_on_full: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_en && $rose(rx_full)) |-> irq);

endmodule

// File: tb/serial_rx_multi_tb.sv
module serial_rx_multi_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int OVS = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic rx_in = 1'b1, sclk_in = 1'b0;
  logic [1:0] mode = 2'd0;
  logic sync_frame_en = 1'b0, parity_en = 1'b0, parity_odd = 1'b0, irq_en = 1'b0;
  logic rd_ack = 1'b0, err_clr = 1'b0;
  logic [7:0] rx_data;
  logic rx_adr_bit, rx_full, par_err, ovr_err, frm_err, irq;

  int n_chk = 0, n_fail = 0;

  typedef struct {
    logic [7:0] d;
    logic a, pe, fe, oe;
    string req;
  } exp_t;
  exp_t sbq[$];

  serial_rx_multi #(.OVS(OVS), .DW(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .rx_in(rx_in), .sclk_in(sclk_in), .mode(mode),
    .sync_frame_en(sync_frame_en), .parity_en(parity_en), .parity_odd(parity_odd),
    .irq_en(irq_en), .rd_ack(rd_ack), .err_clr(err_clr), .rx_data(rx_data),
    .rx_adr_bit(rx_adr_bit), .rx_full(rx_full), .par_err(par_err),
    .ovr_err(ovr_err), .frm_err(frm_err), .irq(irq)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(logic [7:0] d, logic a, logic pe, logic fe, logic oe, string req);
    exp_t e;
    e.d = d; e.a = a; e.pe = pe; e.fe = fe; e.oe = oe; e.req = req;
    sbq.push_back(e);
  endtask

  task automatic send_async(logic [8:0] bits, int n, logic stop);
    @(negedge clk) rx_in = 1'b0;
    repeat (OVS) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      rx_in = bits[i];
      repeat (OVS) @(negedge clk);
    end
    rx_in = stop;
    repeat (OVS) @(negedge clk);
    rx_in = 1'b1;
    repeat (2 * OVS) @(negedge clk);
  endtask

  task automatic sclk_bit(logic b, logic ack);
    rx_in = b;
    repeat (4) @(negedge clk);
    sclk_in = 1'b1;
    repeat (2) @(negedge clk);
    if (ack) rd_ack = 1'b1;
    @(negedge clk) rd_ack = 1'b0;
    @(negedge clk) sclk_in = 1'b0;
  endtask

  task automatic send_sync(logic [7:0] d, logic framed, logic stop, logic ack_last);
    @(negedge clk);
    if (framed) sclk_bit(1'b0, 1'b0);
    for (int i = 0; i < 8; i++) sclk_bit(d[i], ack_last && i == 7 && !framed);
    if (framed) sclk_bit(stop, 1'b0);
    repeat (6) @(negedge clk);
  endtask

  task automatic pulse_ack(logic errs);
    @(negedge clk) begin rd_ack = 1'b1; err_clr = errs; end
    @(negedge clk) begin rd_ack = 1'b0; err_clr = 1'b0; end
  endtask

  initial begin : monitor
    logic full_q, ovr_q;
    full_q = 1'b0; ovr_q = 1'b0;
    forever begin
      @(negedge clk);
      if (rst_n && ((rx_full && !full_q) || (ovr_err && !ovr_q))) begin
        if (sbq.size() == 0) begin
          check("SB unexpected", 1, 0);
        end else begin
          exp_t e;
          e = sbq.pop_front();
          check({e.req, " full"}, rx_full, 1'b1);
          check({e.req, " par_err"}, par_err, e.pe);
          check({e.req, " frm_err"}, frm_err, e.fe);
          check({e.req, " ovr_err"}, ovr_err, e.oe);
          if (!e.pe && !e.fe && !e.oe) begin
            check({e.req, " data"}, rx_data, e.d);
            check({e.req, " adr"}, rx_adr_bit, e.a);
          end
        end
      end
      full_q = rx_full;
      ovr_q = ovr_err;
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    check("watchdog", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : driver
    logic [6:0] d7;
    logic p;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R8 reset full", rx_full, 0);
    check("R8 reset errors", {par_err, ovr_err, frm_err}, 0);
    check("R9 reset irq", irq, 0);

    // R1 plain async byte, then interrupt gating
    push(8'hA5, 0, 0, 0, 0, "R1");
    send_async({1'b0, 8'hA5}, 8, 1'b1);
    check("R9 irq masked", irq, 0);
    irq_en = 1'b1;
    #1 check("R9 irq enabled", irq, 1);
    pulse_ack(1'b0);
    check("R8 ack clears full", rx_full, 0);
    check("R9 irq drops", irq, 0);
    push(8'h3C, 0, 0, 0, 0, "R1");
    send_async({1'b0, 8'h3C}, 8, 1'b1);
    pulse_ack(1'b0);

    // R2 glitch on idle line
    @(negedge clk) rx_in = 1'b0;
    repeat (4) @(negedge clk);
    rx_in = 1'b1;
    repeat (3 * OVS) @(negedge clk);
    check("R2 glitch ignored", {rx_full, frm_err}, 0);
    push(8'h81, 0, 0, 0, 0, "R2");
    send_async({1'b0, 8'h81}, 8, 1'b1);
    pulse_ack(1'b0);

    // R3 parity, mode 0
    parity_en = 1'b1;
    d7 = 7'h35; p = ^d7;
    push({1'b0, d7}, 0, 0, 0, 0, "R3 even ok");
    send_async({1'b0, p, d7}, 8, 1'b1);
    pulse_ack(1'b0);
    parity_odd = 1'b1;
    push({1'b0, d7}, 0, 1, 0, 0, "R3 odd bad");
    send_async({1'b0, p, d7}, 8, 1'b1);
    pulse_ack(1'b1);
    check("R8 err_clr clears par", par_err, 0);
    d7 = 7'h4B; p = ~(^d7);
    push({1'b0, d7}, 0, 0, 0, 0, "R3 odd ok");
    send_async({1'b0, p, d7}, 8, 1'b1);
    pulse_ack(1'b0);

    // R4 mode 3: parity slot stripped, unchecked
    mode = 2'd3; parity_odd = 1'b0;
    d7 = 7'h21; p = ~(^d7);
    push({1'b0, d7}, 0, 0, 0, 0, "R4 mode3 parity");
    send_async({1'b0, p, d7}, 8, 1'b1);
    pulse_ack(1'b0);
    parity_en = 1'b0;
    push(8'hC3, 0, 0, 0, 0, "R4 mode3 plain");
    send_async({1'b0, 8'hC3}, 8, 1'b1);
    pulse_ack(1'b0);

    // R5 mode 1 marker bit, parity_en has no effect
    mode = 2'd1; parity_en = 1'b1;
    push(8'h5A, 1, 0, 0, 0, "R5 adr");
    send_async({1'b1, 8'h5A}, 9, 1'b1);
    pulse_ack(1'b0);
    push(8'hE7, 0, 0, 0, 0, "R5 data");
    send_async({1'b0, 8'hE7}, 9, 1'b1);
    pulse_ack(1'b0);
    parity_en = 1'b0;

    // R6 framing error
    mode = 2'd0;
    push(8'h00, 0, 0, 1, 0, "R6 stop low");
    send_async({1'b0, 8'h77}, 8, 1'b0);
    pulse_ack(1'b1);
    check("R8 err_clr clears frm", frm_err, 0);

    // R7 overrun keeps first byte
    push(8'h11, 0, 0, 0, 0, "R7 first");
    send_async({1'b0, 8'h11}, 8, 1'b1);
    push(8'h22, 0, 0, 0, 1, "R7 overrun");
    send_async({1'b0, 8'h22}, 8, 1'b1);
    @(negedge clk) err_clr = 1'b1;
    @(negedge clk) err_clr = 1'b0;
    check("R7 old byte kept", rx_data, 8'h11);
    check("R7 full kept", rx_full, 1);
    pulse_ack(1'b0);

    // R11 synchronous framed
    mode = 2'd2; sync_frame_en = 1'b1;
    repeat (4) @(negedge clk);
    push(8'h96, 0, 0, 0, 0, "R11 ok");
    send_sync(8'h96, 1'b1, 1'b1, 1'b0);
    pulse_ack(1'b0);
    push(8'h00, 0, 0, 1, 0, "R11 stop low");
    send_sync(8'h69, 1'b1, 1'b0, 1'b0);
    pulse_ack(1'b1);

    // R10 synchronous unframed
    sync_frame_en = 1'b0;
    repeat (4) @(negedge clk);
    push(8'h3C, 0, 0, 0, 0, "R10");
    send_sync(8'h3C, 1'b0, 1'b1, 1'b0);
    check("R10 full after eighth edge", rx_full, 1);

    // R7 read strobe in the completion cycle
    send_sync(8'hE1, 1'b0, 1'b1, 1'b1);
    check("R7 coincident ack no overrun", ovr_err, 0);
    check("R7 coincident ack full", rx_full, 1);
    check("R7 coincident ack data", rx_data, 8'hE1);
    pulse_ack(1'b0);

    repeat (10) @(negedge clk);
    check("SB drained", sbq.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule